// File: doc/BRIEF.md
# FEC Lane Distributor with Periodic Alignment Marker

This block sits after a Reed-Solomon encoder and spreads the encoded 10-bit symbols over four FEC lanes. Each accepted symbol leaves on exactly one lane, one cycle after it is accepted. Lane choice rotates 0,1,2,3,0,... and restarts at lane 0 at every codeword boundary. A 528-symbol codeword therefore places 132 symbols on each lane and every codeword fills the lanes evenly.

The block counts codewords. Once a full period of codewords has passed (4096 by default), it sends an alignment marker group before the next codeword. It also sends one right after reset, so that codeword 0 of every period is preceded by a marker. The 320-bit group gives 80 bits to each lane, which is 8 symbols per lane. Each lane has its own fixed pattern, set by a parameter. While the marker goes out, the input is held off by dropping the ready signal. A marker-active flag travels with the lane outputs so that the next stage can tell marker symbols from data.

A start-of-codeword flag on the input forces the symbol that carries it onto lane 0 and starts a new codeword count. This lets the upstream encoder re-align the distributor.

Top module: `fec_lane_dist`

## Requirements
- R1: While `rst_n` is low, `lane_vld` is all zero and `lane_mrk` and `sym_rdy` are low. After release, a marker group goes out before any data symbol.
- R2: A marker group is LANES*8 consecutive output cycles with `lane_mrk` high. In the j-th cycle (j from 0), only lane j%4 is valid. Its symbol is `MRK_PAT[L*80 + 79 - 10*(j/4) -: 10]` with L = j%4, so each lane sends its 80-bit slice most significant symbol first. The group starts on lane 0.
- R3: `sym_rdy` is low in exactly the cycles in which a marker group is being emitted. An input held valid during that time is not taken and appears exactly once, after the marker.
- R4: A symbol accepted (`sym_vld` and `sym_rdy` high) at a clock edge is driven at that edge onto exactly one lane, with that lane's `lane_vld` bit high and `lane_mrk` low. At most one lane is valid in any cycle.
- R5: Within a codeword of CW_SYMS symbols, the k-th symbol (k from 0) goes to lane k%4. The next codeword starts again at lane 0.
- R6: After the last symbol of every PERIOD-th codeword is accepted, the marker group starts on the very next output cycle.
- R7: Cycles with `sym_vld` low produce no lane output and do not advance the lane position.
- R8: A symbol accepted with `sym_sof` high goes to lane 0 even mid-codeword, and the symbols after it continue from lane 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_vld | input | 1 | Input symbol valid |
| sym_sof | input | 1 | Input symbol is the first of a codeword |
| sym_dat | input | SYM_W | Encoded symbol |
| sym_rdy | output | 1 | Block can take a symbol this cycle |
| lane_vld | output | LANES | Per-lane symbol strobe |
| lane_dat | output | LANES*SYM_W | Lane symbols, lane L at bits [L*SYM_W +: SYM_W] |
| lane_mrk | output | 1 | Current lane symbol belongs to a marker group |

## Verification
A back-to-back stream of full codewords with a start flag on each shows the lane rotation and shows that the marker comes exactly after the last codeword of a period. A stream with irregular idle gaps shows that the position moves only on accepted symbols. A symbol held valid across the marker shows that nothing is taken while ready is low. A start flag placed mid-codeword shows the forced return to lane 0. A short codeword and period are used so that several marker periods fit in a run. The marker content check compares each lane against its own pattern slice, which catches swapped lanes and reversed symbol order.

// File: rtl/fld_pkg.sv
// Shared types and helpers for the FEC lane distributor.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package fld_pkg;

    // Emission mode of the distributor.
    typedef enum logic {
        ST_MRK  = 1'b0,
        ST_DATA = 1'b1
    } fld_state_e;

    // Index width for a counter holding 0..n-1, at least one bit.
    function automatic int unsigned fld_idx_w(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/fld_pos_cnt.sv
// Tracks the position of the next symbol inside its codeword, the lane it
// goes to and the number of codewords seen in the current marker period.
// Assumes: CW_SYMS is a multiple of LANES; a start flag forces position 0.
module fld_pos_cnt
    import fld_pkg::*;
#(
    parameter int unsigned LANES   = 4,
    parameter int unsigned CW_SYMS = 528,
    parameter int unsigned PERIOD  = 4096,
    localparam int unsigned LANE_W = fld_idx_w(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              sof,
    output logic [LANE_W-1:0] lane,
    output logic              period_end
);
    localparam int unsigned POS_W = fld_idx_w(CW_SYMS);
    localparam int unsigned CW_W  = fld_idx_w(PERIOD);

    logic [POS_W-1:0]  pos_q, pos_eff;
    logic [LANE_W-1:0] lane_q, lane_eff, lane_nx;
    logic [CW_W-1:0]   cw_q;
    logic              sym_last, cw_last;

    // Effective position of the symbol on the input this cycle.
    always_comb begin
        pos_eff  = sof ? '0 : pos_q;
        lane_eff = sof ? '0 : lane_q;
        sym_last = (pos_eff == POS_W'(CW_SYMS - 1));
        cw_last  = (cw_q == CW_W'(PERIOD - 1));
        lane_nx  = (lane_eff == LANE_W'(LANES - 1)) ? '0 : lane_eff + 1'b1;
    end

    assign lane       = lane_eff;
    assign period_end = take && sym_last && cw_last;

    // Advance symbol, lane and codeword counters on each accepted symbol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q  <= '0;
            lane_q <= '0;
            cw_q   <= '0;
        end else if (take) begin
            pos_q  <= sym_last ? '0 : pos_eff + 1'b1;
            lane_q <= sym_last ? '0 : lane_nx;
            if (sym_last) begin
                cw_q <= cw_last ? '0 : cw_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fld_mrk_gen.sv
// Steps through the alignment marker group one symbol per enabled cycle,
// dealing symbols to lanes in rotation, each lane's slice MSB symbol first.
// Assumes: MRK_BITS divides evenly into LANES slices of whole symbols.
module fld_mrk_gen
    import fld_pkg::*;
#(
    parameter int unsigned       LANES    = 4,
    parameter int unsigned       SYM_W    = 10,
    parameter int unsigned       MRK_BITS = 320,
    parameter logic [MRK_BITS-1:0] MRK_PAT = '0,
    localparam int unsigned      LANE_W   = fld_idx_w(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    output logic [LANE_W-1:0] mlane,
    output logic [SYM_W-1:0]  msym,
    output logic              mlast
);
    localparam int unsigned LANE_BITS = MRK_BITS / LANES;
    localparam int unsigned SPL       = LANE_BITS / SYM_W;
    localparam int unsigned TOT       = SPL * LANES;
    localparam int unsigned IDX_W     = fld_idx_w(TOT);
    localparam int unsigned SLOT_W    = fld_idx_w(SPL);

    logic [SYM_W-1:0]  tbl [LANES][SPL];
    logic [IDX_W-1:0]  idx_q;
    logic [SLOT_W-1:0] slot;

    // Slice the pattern into per-lane symbol tables.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        for (genvar s = 0; s < SPL; s++) begin : g_slot
            assign tbl[l][s] = MRK_PAT[l*LANE_BITS + LANE_BITS - 1 - s*SYM_W -: SYM_W];
        end
    end

    // Map the running index to lane and slot.
    always_comb begin
        mlane = LANE_W'(idx_q % IDX_W'(LANES));
        slot  = SLOT_W'(idx_q / IDX_W'(LANES));
        msym  = tbl[mlane][slot];
        mlast = (idx_q == IDX_W'(TOT - 1));
    end

    // Step the marker index while the group is being sent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (en) begin
            idx_q <= mlast ? '0 : idx_q + 1'b1;
        end
    end

endmodule

// File: rtl/fld_seq.sv
// Chooses between marker emission and data acceptance.
// Assumes: starts in marker mode so a marker precedes the first codeword.
module fld_seq
    import fld_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mlast,
    input  logic       period_end,
    output fld_state_e state
);
    // Switch mode at the end of a marker group or of a period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_MRK;
        end else begin
            case (state)
                ST_MRK:  if (mlast)      state <= ST_DATA;
                default: if (period_end) state <= ST_MRK;
            endcase
        end
    end

endmodule

// File: rtl/fec_lane_dist.sv
// Distributes encoded RS symbols over FEC lanes with a periodic alignment
// marker group placed before codeword 0 of each period.
// Assumes: LANES >= 2, CW_SYMS multiple of LANES, MRK_BITS multiple of
// LANES*SYM_W. Input is held off while the marker is sent.
module fec_lane_dist
    import fld_pkg::*;
#(
    parameter int unsigned         SYM_W    = 10,
    parameter int unsigned         LANES    = 4,
    parameter int unsigned         CW_SYMS  = 528,
    parameter int unsigned         PERIOD   = 4096,
    parameter int unsigned         MRK_BITS = 320,
    parameter logic [MRK_BITS-1:0] MRK_PAT  = {80'hC1A5_0F3C_96E1_7B2D_48F0,
                                               80'h5AA5_3C3C_0FF0_9669_1248,
                                               80'h2E71_D38B_64A9_F10C_57BE,
                                               80'h8D4B_16E2_A03F_C975_2C61}
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sym_vld,
    input  logic                   sym_sof,
    input  logic [SYM_W-1:0]       sym_dat,
    output logic                   sym_rdy,
    output logic [LANES-1:0]       lane_vld,
    output logic [LANES*SYM_W-1:0] lane_dat,
    output logic                   lane_mrk
);
    localparam int unsigned LANE_W = fld_idx_w(LANES);

    fld_state_e        state;
    logic              take, in_mrk, mlast, period_end;
    logic [LANE_W-1:0] dlane, mlane;
    logic [SYM_W-1:0]  msym;

    assign in_mrk  = (state == ST_MRK);
    assign sym_rdy = (state == ST_DATA);
    assign take    = sym_vld && sym_rdy;

    fld_pos_cnt #(.LANES(LANES), .CW_SYMS(CW_SYMS), .PERIOD(PERIOD)) u_pos (
        .clk(clk), .rst_n(rst_n), .take(take), .sof(sym_sof),
        .lane(dlane), .period_end(period_end)
    );

    fld_mrk_gen #(.LANES(LANES), .SYM_W(SYM_W), .MRK_BITS(MRK_BITS), .MRK_PAT(MRK_PAT)) u_mrk (
        .clk(clk), .rst_n(rst_n), .en(in_mrk),
        .mlane(mlane), .msym(msym), .mlast(mlast)
    );

    fld_seq u_seq (
        .clk(clk), .rst_n(rst_n), .mlast(mlast),
        .period_end(period_end), .state(state)
    );

    // Register one marker or data symbol onto its lane per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_vld <= '0;
            lane_dat <= '0;
            lane_mrk <= 1'b0;
        end else begin
            lane_vld <= '0;
            lane_mrk <= 1'b0;
            if (in_mrk) begin
                lane_vld[mlane]                <= 1'b1;
                lane_dat[mlane*SYM_W +: SYM_W] <= msym;
                lane_mrk                       <= 1'b1;
            end else if (take) begin
                lane_vld[dlane]                <= 1'b1;
                lane_dat[dlane*SYM_W +: SYM_W] <= sym_dat;
            end
        end
    end

endmodule

// File: rtl/fec_lane_dist_chk.sv
// Property checker for fec_lane_dist, attached by bind.
// Assumes: the marker group is LANES*(MRK_BITS/LANES/SYM_W) symbols long.
module fec_lane_dist_chk
    import fld_pkg::*;
#(
    parameter int unsigned SYM_W    = 10,
    parameter int unsigned LANES    = 4,
    parameter int unsigned MRK_BITS = 320
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sym_vld,
    input logic             sym_sof,
    input logic             sym_rdy,
    input logic [LANES-1:0] lane_vld,
    input logic             lane_mrk
);
    localparam int unsigned TOT   = (MRK_BITS / LANES / SYM_W) * LANES;
    localparam int unsigned RUN_W = fld_idx_w(TOT + 1);

    logic [RUN_W-1:0] run_q;

    // Count consecutive marker cycles already seen.
    always_ff @(posedge clk) begin
        if (!rst_n)        run_q <= '0;
        else if (lane_mrk) run_q <= run_q + 1'b1;
        else               run_q <= '0;
    end

    AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lane_vld)); // R4
    AST_TAKE_TO_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_vld && sym_rdy) |=> (|lane_vld && !lane_mrk)); // R4
    AST_HOLD_IN_MRK: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_rdy |=> (|lane_vld && lane_mrk)); // R3
    AST_SOF_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_vld && sym_rdy && sym_sof) |=> lane_vld[0]); // R8
    AST_MRK_FROM_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lane_mrk) |-> lane_vld[0]); // R2
    AST_MRK_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        lane_mrk |-> (run_q < RUN_W'(TOT))); // R2
    AST_MRK_END: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_mrk && run_q == RUN_W'(TOT - 1)) |=> !lane_mrk); // R2

endmodule

bind fec_lane_dist fec_lane_dist_chk #(
    .SYM_W(SYM_W), .LANES(LANES), .MRK_BITS(MRK_BITS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sym_vld(sym_vld), .sym_sof(sym_sof),
    .sym_rdy(sym_rdy), .lane_vld(lane_vld), .lane_mrk(lane_mrk)
);

// File: tb/fec_lane_dist_tb.sv
// Directed bench for fec_lane_dist with a short codeword and period.
module fec_lane_dist_tb;
    localparam int unsigned SYM_W = 10;
    localparam int unsigned LANES = 4;
    localparam int unsigned CW    = 16;
    localparam int unsigned PER   = 4;
    localparam int unsigned MBITS = 320;
    localparam int unsigned MTOT  = 32;
    localparam logic [MBITS-1:0] PAT = {80'hA1B2_C3D4_E5F6_0718_293A,
                                        80'h0F1E_2D3C_4B5A_6978_8796,
                                        80'h1357_9BDF_0246_8ACE_1357,
                                        80'hFEDC_BA98_7654_3210_0123};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sym_vld = 1'b0, sym_sof = 1'b0;
    logic [SYM_W-1:0] sym_dat = '0;
    logic sym_rdy;
    logic [LANES-1:0] lane_vld;
    logic [LANES*SYM_W-1:0] lane_dat;
    logic lane_mrk;

    int errors = 0, checks = 0, cyc = 0, n = 0;
    int lg_lane [256];
    logic [SYM_W-1:0] lg_dat [256];
    logic lg_mrk [256];
    int lg_cyc [256];

    always #10 clk = ~clk;
    always @(posedge clk) cyc++;

    fec_lane_dist #(.SYM_W(SYM_W), .LANES(LANES), .CW_SYMS(CW), .PERIOD(PER),
                    .MRK_BITS(MBITS), .MRK_PAT(PAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .sym_vld(sym_vld), .sym_sof(sym_sof),
        .sym_dat(sym_dat), .sym_rdy(sym_rdy), .lane_vld(lane_vld),
        .lane_dat(lane_dat), .lane_mrk(lane_mrk)
    );

    // Log every valid lane output.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int l = 0; l < LANES; l++) begin
                if (lane_vld[l] && n < 256) begin
                    lg_lane[n] = l;
                    lg_dat[n]  = lane_dat[l*SYM_W +: SYM_W];
                    lg_mrk[n]  = lane_mrk;
                    lg_cyc[n]  = cyc;
                    n++;
                end
            end
        end
    end

    function automatic logic [SYM_W-1:0] mrk_exp(input int j);
        int l = j % LANES;
        return PAT[l*80 + 79 - 10*(j/LANES) -: 10];
    endfunction

    function automatic logic [SYM_W-1:0] dval(input int tag, input int i);
        return SYM_W'(tag*97 + i*13 + 5);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_ev(input int i, input int el, input logic [SYM_W-1:0] ed,
                          input logic em, input string req);
        checks++;
        if (i >= n) begin
            errors++;
            $display("FAIL %s entry %0d missing: actual count=%0d expected>%0d", req, i, n, i);
        end else if (lg_lane[i] != el || lg_dat[i] != ed || lg_mrk[i] != em) begin
            errors++;
            $display("FAIL %s entry %0d: actual lane=%0d dat=%h mrk=%0b expected lane=%0d dat=%h mrk=%0b",
                     req, i, lg_lane[i], lg_dat[i], lg_mrk[i], el, ed, em);
        end
    endtask

    task automatic chk_marker(input int base, input string req);
        for (int j = 0; j < MTOT; j++) chk_ev(base + j, j % LANES, mrk_exp(j), 1'b1, req);
    endtask

    // Offer one symbol and wait until it is accepted.
    task automatic send(input logic [SYM_W-1:0] d, input logic sof);
        sym_vld = 1'b1; sym_dat = d; sym_sof = sof;
        while (!sym_rdy) begin @(negedge clk); #1; end
        @(negedge clk); #1;
        sym_vld = 1'b0; sym_sof = 1'b0;
    endtask

    task automatic settle(input int k);
        repeat (k) @(negedge clk);
        #1;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        settle(3);
        chk(lane_vld == '0, "R1", "lane_vld in reset", lane_vld, 0);
        chk(lane_mrk == 1'b0, "R1", "lane_mrk in reset", lane_mrk, 0);
        chk(sym_rdy == 1'b0, "R1", "sym_rdy in reset", sym_rdy, 0);
    endtask

    task automatic t_first_marker;
        int lo = 0;
        n = 0;
        rst_n = 1'b1;
        #1;
        while (!sym_rdy && lo < 100) begin lo++; @(negedge clk); #1; end
        chk(lo == MTOT, "R3", "ready-low cycles after reset", lo, MTOT);
        chk(n == MTOT, "R1", "outputs before first data", n, MTOT);
        chk_marker(0, "R2");
    endtask

    task automatic t_full_period;
        n = 0;
        for (int c = 0; c < PER; c++)
            for (int k = 0; k < CW; k++) send(dval(c, k), k == 0);
        settle(MTOT + 1);
        for (int i = 0; i < PER*CW; i++) chk_ev(i, i % LANES, dval(i / CW, i % CW), 1'b0, "R5");
        chk(n == PER*CW + MTOT, "R6", "entries over period", n, PER*CW + MTOT);
        chk(lg_cyc[PER*CW] == lg_cyc[PER*CW-1] + 1, "R6", "marker follows last codeword",
            lg_cyc[PER*CW] - lg_cyc[PER*CW-1], 1);
        chk_marker(PER*CW, "R6");
        chk(sym_rdy == 1'b1, "R3", "ready after marker", sym_rdy, 1);
    endtask

    task automatic t_gaps;
        n = 0;
        for (int i = 0; i < 2*CW; i++) begin
            send(dval(7, i), (i % CW) == 0);
            settle(i % 3);
        end
        settle(2);
        chk(n == 2*CW, "R7", "entries with gaps", n, 2*CW);
        for (int i = 0; i < 2*CW; i++) chk_ev(i, i % LANES, dval(7, i), 1'b0, "R7");
    endtask

    task automatic t_backpressure;
        n = 0;
        for (int i = 0; i < 2*CW; i++) send(dval(9, i), (i % CW) == 0);
        send(10'h2AB, 1'b1);
        settle(2);
        for (int i = 0; i < 2*CW; i++) chk_ev(i, i % LANES, dval(9, i), 1'b0, "R4");
        chk_marker(2*CW, "R6");
        chk_ev(2*CW + MTOT, 0, 10'h2AB, 1'b0, "R3");
        chk(n == 2*CW + MTOT + 1, "R3", "held symbol taken once", n, 2*CW + MTOT + 1);
    endtask

    task automatic t_sof_resync;
        n = 0;
        for (int k = 1; k <= 5; k++) send(dval(11, k), 1'b0);
        send(10'h155, 1'b1);
        send(10'h0AA, 1'b0);
        settle(2);
        for (int k = 1; k <= 5; k++) chk_ev(k - 1, k % LANES, dval(11, k), 1'b0, "R5");
        chk_ev(5, 0, 10'h155, 1'b0, "R8");
        chk_ev(6, 1, 10'h0AA, 1'b0, "R8");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        settle(1);
        t_reset();
        t_first_marker();
        t_full_period();
        t_gaps();
        t_backpressure();
        t_sof_resync();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule